// File: doc/BRIEF.md
# Synchronous Half-Duplex Serial Link Transceiver

This block drives a two-wire synchronous link made of a serial clock it generates itself and one shared data line. Bytes are carried in 12-bit frames: a low start bit, eight data bits least significant first, an even parity bit and two high stop bits. The transmitter moves the data line only on falling serial-clock edges. The receiver samples on rising edges and waits for a low start bit before it counts any bit.

A client hands over a byte with a valid/ready handshake, asks for one incoming byte with `rx_req`, or asks for a BREAK frame with `send_break`. A BREAK is a fixed 12-bit pattern (all ones by default) shifted out like any frame. When `enable` rises, the block drives the data line high for a programmable hold time and then sends two BREAK frames before it accepts traffic. Dropping `enable` stops the clock and parks both wires low with their output enables off.

The controller has five states. OFF is left for HOLD when `enable` is high. HOLD goes to SEND once the hold time ends, loading the first BREAK. IDLE goes to SEND on `send_break` or an accepted byte, and to RECV on `rx_req`. SEND reloads a second BREAK when one is owed at frame end, and otherwise returns to IDLE. RECV returns to IDLE once the twelfth bit is in. Any state falls to OFF when `enable` is low.

Top module: `sync_link_xcvr`

## Requirements
- R1: A transmitted byte d appears as 12 bits, least significant first: bit 0 is 0, bits 1..8 are d[0]..d[7], bit 9 is the parity bit, and bits 10 and 11 are 1.
- R2: The parity bit equals the XOR of the eight data bits, so data plus parity carries an even number of ones.
- R3: The serial clock starts low and rises HALF_DIV system clocks after `enable` goes high. Every later half-period also lasts HALF_DIV system clocks.
- R4: While a frame is being sent, `data_out` changes only in the system clock cycle in which `clock_out` falls.
- R5: The receiver samples `data_in` on rising serial-clock edges. While no start bit has arrived, a high sample is ignored.
- R6: After a received frame, `rx_valid` pulses for one cycle with `rx_data` holding the eight bits that followed the start bit.
- R7: A received frame whose data and parity have odd weight sets `rx_parity_err`. The flag stays set through later good frames and clears only on reset or when `enable` is low.
- R8: `rx_req` is accepted only in IDLE. From acceptance, through the whole reception and until the next transmission, `data_oe` is 0.
- R9: In the cycle after a byte or BREAK is accepted, `data_oe` and `data_out` are both 1.
- R10: `send_break` takes priority over `tx_valid` (`tx_ready` is 0 while it is high). It sends exactly 12 falling serial-clock edges of BREAK pattern with the line high.
- R11: One cycle after `enable` rises, `data_oe` and `data_out` are 1 and stay 1 until `tx_ready` rises. That happens after the hold time and exactly 24 falling serial-clock edges (two BREAKs).
- R12: One cycle after `enable` is low, `clock_out`, `clock_oe`, `data_out`, `data_oe` and `rx_valid` are all 0.
- R13: `tx_ready` is 1 only in IDLE, and it is 0 while a frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Link on; its rise starts the wake-up sequence |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Byte accepted when high together with tx_valid |
| send_break | input | 1 | Request one BREAK frame (priority over tx_valid) |
| rx_req | input | 1 | Request reception of one frame |
| rx_valid | output | 1 | One-cycle pulse: rx_data is valid |
| rx_data | output | 8 | Last received byte |
| rx_parity_err | output | 1 | Sticky parity mismatch flag |
| data_in | input | 1 | Data line as read from the pin |
| data_out | output | 1 | Data line drive value |
| data_oe | output | 1 | Data line output enable |
| clock_out | output | 1 | Serial clock |
| clock_oe | output | 1 | Serial clock output enable |

## Verification
A corrupted bit counter shows up within one frame. The bench then sees the wrong number of falling clock edges before `tx_ready` returns, or a captured frame with a shifted field, or an `rx_valid` that arrives early, late or never. A wrong state shows up as a line-drive fault in the same cycle. Examples are `data_oe` high during reception, the line dropping during wake-up, or outputs left on one cycle after `enable` falls. A bad prescaler count shows up on the first serial-clock edge after `enable` rises. Random bytes and parity faults from a fixed seed are checked against a frame built bit by bit in the bench.

// File: rtl/sync_link_pkg.sv
package sync_link_pkg;
    localparam int FRAME_BITS = 12;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    typedef enum logic [2:0] {
        ST_OFF,
        ST_HOLD,
        ST_IDLE,
        ST_SEND,
        ST_RECV
    } link_state_e;

    // start(0) at bit 0, data LSB first, even parity, two stop bits
    function automatic logic [FRAME_BITS-1:0] make_frame(input logic [7:0] d);
        return {2'b11, ^d, d, 1'b0};
    endfunction
endpackage

// File: rtl/sync_link_sclk.sv
module sync_link_sclk #(
    parameter int HALF_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(HALF_DIV - 1);

    logic [DIV_W-1:0] div_cnt;
    logic             wrap;

    assign wrap      = run && (div_cnt == LAST);
    assign rise_tick = wrap && !sclk;
    assign fall_tick = wrap && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            sclk    <= 1'b0;
        end else if (!run) begin
            div_cnt <= '0;
            sclk    <= 1'b0;
        end else if (wrap) begin
            div_cnt <= '0;
            sclk    <= ~sclk;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R3: the serial clock holds its level until the prescaler wraps
    assert_sclk_half_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && div_cnt != LAST) |=> $stable(sclk));
endmodule

// File: rtl/sync_link_shift.sv
module sync_link_shift
    import sync_link_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_val,
    input  logic                  shift_out,
    input  logic                  shift_in,
    input  logic                  in_bit,
    output logic [FRAME_BITS-1:0] frame,
    output logic [CNT_W-1:0]      remain
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame  <= '0;
            remain <= '0;
        end else if (load) begin
            frame  <= load_val;
            remain <= FULL;
        end else if (shift_out) begin
            frame  <= {1'b1, frame[FRAME_BITS-1:1]};
            remain <= remain - 1'b1;
        end else if (shift_in) begin
            frame  <= {in_bit, frame[FRAME_BITS-1:1]};
            remain <= remain - 1'b1;
        end
    end

    // R1: a frame never holds more than twelve bits
    assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        remain <= FULL);
    // R1: no shift once all twelve bits have moved
    assert_no_overshift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_out || shift_in) |-> (remain != '0));
endmodule

// File: rtl/sync_link_xcvr.sv
module sync_link_xcvr
    import sync_link_pkg::*;
#(
    parameter int                    HALF_DIV      = 50,
    parameter int                    HOLD_CYC      = 8,
    parameter logic [FRAME_BITS-1:0] BREAK_PATTERN = '1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    input  logic       send_break,
    input  logic       rx_req,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_parity_err,
    input  logic       data_in,
    output logic       data_out,
    output logic       data_oe,
    output logic       clock_out,
    output logic       clock_oe
);
    localparam int                HOLD_W    = $clog2(HOLD_CYC + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0]  FULL      = CNT_W'(FRAME_BITS);

    link_state_e           st, st_n;
    logic                  rise_tick, fall_tick;
    logic                  sh_load, sh_out, sh_in;
    logic [FRAME_BITS-1:0] sh_val, frame;
    logic [CNT_W-1:0]      remain;
    logic [HOLD_W-1:0]     hold_cnt;
    logic                  brk_left;
    logic                  take_break, take_tx, take_rx;
    logic                  frame_end;

    sync_link_sclk #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .sclk      (clock_out),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    sync_link_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_val  (sh_val),
        .shift_out (sh_out),
        .shift_in  (sh_in),
        .in_bit    (data_in),
        .frame     (frame),
        .remain    (remain)
    );

    assign frame_end = (remain == '0);
    assign tx_ready  = enable && (st == ST_IDLE) && !send_break;

    // next state and datapath strobes
    always_comb begin
        st_n       = st;
        sh_load    = 1'b0;
        sh_val     = '0;
        sh_out     = 1'b0;
        sh_in      = 1'b0;
        take_break = 1'b0;
        take_tx    = 1'b0;
        take_rx    = 1'b0;
        unique case (st)
            ST_OFF: begin
                if (enable) st_n = ST_HOLD;
            end
            ST_HOLD: begin
                if (hold_cnt == HOLD_LAST) begin
                    st_n    = ST_SEND;
                    sh_load = 1'b1;
                    sh_val  = BREAK_PATTERN;
                end
            end
            ST_IDLE: begin
                if (send_break) begin
                    take_break = 1'b1;
                    st_n       = ST_SEND;
                    sh_load    = 1'b1;
                    sh_val     = BREAK_PATTERN;
                end else if (tx_valid) begin
                    take_tx = 1'b1;
                    st_n    = ST_SEND;
                    sh_load = 1'b1;
                    sh_val  = make_frame(tx_data);
                end else if (rx_req) begin
                    take_rx = 1'b1;
                    st_n    = ST_RECV;
                    sh_load = 1'b1;
                end
            end
            ST_SEND: begin
                if (frame_end) begin
                    if (brk_left) begin
                        sh_load = 1'b1;
                        sh_val  = BREAK_PATTERN;
                    end else begin
                        st_n = ST_IDLE;
                    end
                end else begin
                    sh_out = fall_tick;
                end
            end
            ST_RECV: begin
                if (frame_end) st_n = ST_IDLE;
                else sh_in = rise_tick && !((remain == FULL) && data_in);
            end
            default: st_n = ST_OFF;
        endcase
        if (!enable) begin
            st_n       = ST_OFF;
            sh_load    = 1'b0;
            sh_out     = 1'b0;
            sh_in      = 1'b0;
            take_break = 1'b0;
            take_tx    = 1'b0;
            take_rx    = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= st_n;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out      <= 1'b0;
            data_oe       <= 1'b0;
            clock_oe      <= 1'b0;
            rx_valid      <= 1'b0;
            rx_data       <= '0;
            rx_parity_err <= 1'b0;
            brk_left      <= 1'b0;
            hold_cnt      <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (!enable) begin
                data_out      <= 1'b0;
                data_oe       <= 1'b0;
                clock_oe      <= 1'b0;
                rx_parity_err <= 1'b0;
                brk_left      <= 1'b0;
                hold_cnt      <= '0;
            end else begin
                unique case (st)
                    ST_OFF: begin
                        data_out <= 1'b1;
                        data_oe  <= 1'b1;
                        clock_oe <= 1'b1;
                        hold_cnt <= '0;
                    end
                    ST_HOLD: begin
                        hold_cnt <= hold_cnt + 1'b1;
                        if (st_n == ST_SEND) brk_left <= 1'b1;
                    end
                    ST_IDLE: begin
                        if (take_break || take_tx) begin
                            data_out <= 1'b1;
                            data_oe  <= 1'b1;
                        end else if (take_rx) begin
                            data_out <= 1'b0;
                            data_oe  <= 1'b0;
                        end
                    end
                    ST_SEND: begin
                        if (sh_out)    data_out <= frame[0];
                        if (frame_end) brk_left <= 1'b0;
                    end
                    ST_RECV: begin
                        if (frame_end) begin
                            rx_valid <= 1'b1;
                            rx_data  <= frame[8:1];
                            if (^frame[9:1]) rx_parity_err <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: no data change in a send cycle without a falling serial edge
    assert_tx_fall_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEND && st_n == ST_SEND && !fall_tick) |=> $stable(data_out));
    // R5: a high level before the start bit leaves the counter full
    assert_wait_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && st == ST_RECV && remain == FULL && data_in) |=> (remain == FULL));
    // R6: the receive strobe lasts one cycle
    assert_rx_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R8: the line is released for the whole reception
    assert_rx_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RECV) |-> !data_oe);
    // R12: everything is parked one cycle after disable
    assert_off_parked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!clock_out && !clock_oe && !data_out && !data_oe && !rx_valid));
endmodule

// File: tb/sync_link_xcvr_tb.sv
`timescale 1ns/1ps
module sync_link_xcvr_tb;
    localparam int HALF_DIV = 4;
    localparam int HOLD_CYC = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_ready;
    logic       send_break = 1'b0;
    logic       rx_req = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_parity_err;
    logic       data_in = 1'b1;
    logic       data_out, data_oe, clock_out, clock_oe;

    int  total = 0;
    int  bad = 0;
    bit  finished = 0;
    bit  exp_err = 0;

    bit  mon_on = 0;
    int  mon_bad = 0;
    bit  mon_prev_d = 0;
    bit  mon_prev_c = 0;

    always #5 clk = ~clk;

    sync_link_xcvr #(.HALF_DIV(HALF_DIV), .HOLD_CYC(HOLD_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .send_break(send_break), .rx_req(rx_req),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_parity_err(rx_parity_err),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .clock_out(clock_out), .clock_oe(clock_oe)
    );

    // R4 monitor: data_out may move only when clock_out falls
    always @(negedge clk) begin
        if (mon_on && (data_out !== mon_prev_d) && !(mon_prev_c && !clock_out))
            mon_bad++;
        mon_prev_d = data_out;
        mon_prev_c = clock_out;
    end

    function automatic logic [11:0] exp_frame(input logic [7:0] d, input bit flip);
        logic [11:0] f;
        logic        p;
        p = 1'b0;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            f[i+1] = d[i];
            p = p ^ d[i];
        end
        f[9]  = p ^ flip;
        f[10] = 1'b1;
        f[11] = 1'b1;
        return f;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (!tx_ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wake();
        int  n = 1, falls = 0, first_hi = -1, first_lo = -1;
        bit  prev, dropped = 0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        prev = clock_out;
        check("R11", "line driven high after enable", {data_oe, data_out, clock_oe}, 3'b111);
        while (!tx_ready && n < 3000) begin
            @(negedge clk);
            n++;
            if (prev && !clock_out) begin
                falls++;
                if (first_lo < 0) first_lo = n;
            end
            if (!prev && clock_out && first_hi < 0) first_hi = n;
            if (!(data_oe && data_out)) dropped = 1;
            prev = clock_out;
        end
        check("R3", "first serial rise delay", first_hi, HALF_DIV);
        check("R3", "serial high half-period", first_lo - first_hi, HALF_DIV);
        check("R11", "falling edges in wake breaks", falls, 24);
        check("R11", "line dropped during wake", dropped, 0);
    endtask

    task automatic do_tx(input logic [7:0] d);
        logic [11:0] got;
        logic [11:0] exp;
        int  idx = 0;
        bit  oe_lost = 0;
        wait_idle();
        tx_valid = 1'b1;
        tx_data  = d;
        @(negedge clk);
        tx_valid = 1'b0;
        check("R9", "drive on tx accept", {data_oe, data_out}, 2'b11);
        check("R13", "tx_ready while sending", tx_ready, 0);
        #1 mon_on = 1;
        got = '1;
        while (idx < 12) begin
            @(posedge clock_out);
            @(negedge clk);
            if (!data_oe) oe_lost = 1;
            if (idx == 0) begin
                if (data_out == 1'b0) begin
                    got[0] = 1'b0;
                    idx = 1;
                end
            end else begin
                got[idx] = data_out;
                idx++;
            end
        end
        mon_on = 0;
        exp = exp_frame(d, 1'b0);
        check("R1", $sformatf("tx frame of %02h", d), got, exp);
        check("R2", $sformatf("parity bit of %02h", d), got[9], exp[9]);
        check("R4", "data moved off falling edge", mon_bad, 0);
        check("R9", "output enable held during frame", oe_lost, 0);
    endtask

    task automatic do_rx(input logic [7:0] d, input bit flip, input int lead);
        logic [11:0] f;
        int w = 0;
        wait_idle();
        rx_req = 1'b1;
        @(negedge clk);
        rx_req = 1'b0;
        check("R8", "line released on rx accept", data_oe, 0);
        f = exp_frame(d, flip);
        for (int k = 0; k < lead; k++) begin
            @(negedge clock_out);
            @(negedge clk);
            data_in = 1'b1;
        end
        for (int b = 0; b < 12; b++) begin
            @(negedge clock_out);
            @(negedge clk);
            data_in = f[b];
            if (b == 4) check("R8", "line released mid reception", data_oe, 0);
        end
        while (!rx_valid && w < 8 * HALF_DIV) begin
            @(negedge clk);
            w++;
        end
        exp_err = exp_err | flip;
        check("R6", "rx_valid seen", rx_valid, 1);
        check("R6", $sformatf("rx byte lead=%0d", lead), rx_data, d);
        check("R7", "parity error flag", rx_parity_err, exp_err);
        @(negedge clk);
        check("R6", "rx_valid single cycle", rx_valid, 0);
        data_in = 1'b1;
    endtask

    task automatic do_break();
        int  falls = 0;
        bit  prev, dropped = 0;
        wait_idle();
        send_break = 1'b1;
        tx_valid   = 1'b1;
        tx_data    = 8'h00;
        #1 check("R10", "tx_ready masked by break", tx_ready, 0);
        @(negedge clk);
        send_break = 1'b0;
        tx_valid   = 1'b0;
        check("R9", "drive on break accept", {data_oe, data_out}, 2'b11);
        prev = clock_out;
        for (int n = 0; n < 3000 && !tx_ready; n++) begin
            @(negedge clk);
            if (prev && !clock_out) falls++;
            if (!(data_oe && data_out)) dropped = 1;
            prev = clock_out;
        end
        check("R10", "falling edges in one break", falls, 12);
        check("R10", "break line level", dropped, 0);
    endtask

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd9173);
        repeat (3) @(negedge clk);
        check("R12", "reset outputs", {clock_out, clock_oe, data_out, data_oe, rx_valid, tx_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        wake();

        do_tx(8'h00);
        do_tx(8'hFF);
        do_tx(8'hA5);
        do_break();

        do_rx(8'h3C, 1'b0, 3);
        do_rx(8'h81, 1'b1, 0);
        do_rx(8'h5A, 1'b0, 1);
        check("R8", "line stays released in idle", data_oe, 0);
        do_tx(8'h01);

        for (int it = 0; it < 16; it++) begin
            logic [7:0] d;
            d = 8'($urandom);
            if ($urandom % 2) do_tx(d);
            else do_rx(d, ($urandom % 4) == 0, int'($urandom % 3));
        end

        wait_idle();
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R12", "parked after disable", {clock_out, clock_oe, data_out, data_oe, rx_valid, tx_ready}, 0);
        check("R7", "error flag cleared by disable", rx_parity_err, 0);
        begin
            bit moved = 0;
            repeat (3 * HALF_DIV) begin
                @(negedge clk);
                if (clock_out) moved = 1;
            end
            check("R12", "clock stopped while disabled", moved, 0);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule